// File: doc/BRIEF.md
# Compressed Instruction Line Refill Engine

This block sits between an instruction cache and a main memory that stores the program as Huffman-coded bytes. When the cache misses, it supplies the number of the uncompressed line it needs. The engine looks that number up in a translation table to find the word-aligned byte address where the line's compressed block begins. It then reads 32-bit words from memory into a 64-bit bit buffer and decodes the bits one at a time against a canonical code. It gathers 32 decoded bytes and returns them to the cache as one 256-bit line. The cache therefore only ever holds plain instructions.

Every block is decoded from its own first bit, so a branch into any line can be served. The decoder never reads bits left over from an earlier line. Any unused bits at the end of a block are thrown away, along with any word fetched past the end of the block. The code tables and the translation table are registers, loaded through a small write port. Data-side reads and writes share the memory port: they pass through unchanged whenever no refill is pending or active.

Top module: `cline_refill`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lineValid`, `lineErr`, `memReqValid` and `dRespValid` are low.
- R2: A refill of line `missLine` first reads memory at the byte address held in translation entry `missLine`. This entry is written with `cfgSel`=0, where `cfgAddr` holds the entry number and `cfgData` the address, whose bits [1:0] are ignored. Each later refill read is at the previous address plus 4.
- R3: Bits are used from bit 31 of each memory word down to bit 0, one bit per decode step. After L bits of the current code have been read, they are taken as an L-bit value c. If firstCode[L] <= c < firstCode[L]+count[L], the decoded byte is symbol[base[L] + c - firstCode[L]], counted modulo 256. firstCode[L] is written with `cfgSel`=1, `cfgAddr`=L-1 and `cfgData`[15:0]. count[L] and base[L] are written with `cfgSel`=2, `cfgAddr`=L-1, count in `cfgData`[8:0] and base in `cfgData`[23:16]. The symbol table is written with `cfgSel`=3, `cfgAddr` = index and `cfgData`[7:0] = byte.
- R4: The k-th decoded byte of a line (k = 0..31) appears at `lineData`[8k+7:8k]. `lineValid` is high for exactly one cycle once all 32 bytes are present. The cache holds `missValid` until it sees `lineValid` or `lineErr`.
- R5: Decoding of each refill starts at the first bit of the block. Padding bits after the 32nd symbol, and words fetched beyond the block, do not affect this refill or any later one. The same line refilled twice gives the same data.
- R6: If 16 bits are read without a match, the refill is abandoned. `lineErr` pulses for one cycle and `lineValid` stays low. The next refill works normally.
- R7: A data request is passed to memory with its address, write enable and write data unchanged. A data read returns the memory word unchanged on `dRespData` with `dRespValid`.
- R8: At most one refill read is waiting for its response at any time.
- R9: `dReqReady` is low whenever `missValid` is high or a refill is in progress. Only one data read may be waiting at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table select: 0 translation, 1 first code, 2 count/base, 3 symbol |
| cfgAddr | input | 8 | Entry number within the selected table |
| cfgData | input | 32 | Write data |
| missValid | input | 1 | Instruction line refill requested, held until answered |
| missLine | input | 8 | Uncompressed line number (table index) |
| lineValid | output | 1 | One-cycle pulse: line ready |
| lineErr | output | 1 | One-cycle pulse: invalid code, refill abandoned |
| lineData | output | 256 | Decoded line, byte k at bits [8k+7:8k] |
| dReqValid | input | 1 | Data request valid |
| dReqReady | output | 1 | Data request accepted |
| dReqWe | input | 1 | Data request is a write |
| dReqAddr | input | 32 | Data byte address |
| dReqWdata | input | 32 | Data write word |
| dRespValid | output | 1 | Data read response valid |
| dRespData | output | 32 | Data read word |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqWe | output | 1 | Memory request is a write |
| memReqAddr | output | 32 | Memory byte address |
| memReqWdata | output | 32 | Memory write word |
| memRespValid | input | 1 | Memory read response valid |
| memRespData | input | 32 | Memory read word |

## Verification
The bench builds the block with its default parameters: a 256-entry translation table, 8-bit symbols, 16-bit maximum code length and a 32-byte line. It loads a canonical code with 2-, 4- and 10-bit codes and leaves the top of the code space unassigned. Eight lines each carry a different set of 32 symbol indices, so together they decode every one of the 256 symbols. Other lines use only the shortest codes, a mix of lengths, and only the longest codes. Blocks are separated by padding of all ones and are refilled out of order. A block made entirely of ones exercises the invalid-code path. The memory model varies its response latency and its ready signal, and a data read is raised during a refill.

// File: rtl/clr_pkg.sv
package clr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_DONE  = 3'd3,
    ST_ERR   = 3'd4
  } refillState_t;

  typedef enum logic [1:0] {
    CFG_XLAT    = 2'd0,
    CFG_FIRST   = 2'd1,
    CFG_CNTBASE = 2'd2,
    CFG_SYM     = 2'd3
  } cfgSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;  // load block address, clear buffer and decode state
    logic run;    // fetch and decode enabled
  } ctrlStrobe_t;

endpackage

// File: rtl/clr_dpath.sv
module clr_dpath
  import clr_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int LINE_SYMS = 32,
  parameter int MAX_LEN   = 16,
  parameter int LAT_AW    = 8,
  parameter int MEM_W     = 32,
  parameter int BUF_W     = 64,
  parameter int ADDR_W    = 32,
  parameter int CFG_AW    = 8,
  localparam int LINE_W   = SYM_W * LINE_SYMS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [MEM_W-1:0]  cfgData,
  input  logic [LAT_AW-1:0] lineIdx,
  input  logic              memReqReady,
  input  logic              memRespValid,
  input  logic [MEM_W-1:0]  memRespData,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              lineFull,
  output logic              codeErr,
  output logic              refPend,
  output logic [LINE_W-1:0] lineData
);

  localparam int LAT_N    = 2 ** LAT_AW;
  localparam int SYM_N    = 2 ** SYM_W;
  localparam int LEN_IW   = $clog2(MAX_LEN);
  localparam int CNT_W    = $clog2(BUF_W + 1);
  localparam int SIDX_W   = $clog2(LINE_SYMS + 1);
  localparam int SSEL_W   = $clog2(LINE_SYMS);
  localparam int BASE_LSB = MEM_W / 2;
  localparam int PTR_W    = ADDR_W - 2;

  // ---------------- tables ----------------
  logic [PTR_W-1:0]   xlatMem   [LAT_N];
  logic [MAX_LEN-1:0] firstCode [MAX_LEN];
  logic [SYM_W:0]     codeCnt   [MAX_LEN];
  logic [SYM_W-1:0]   codeBase  [MAX_LEN];
  logic [SYM_W-1:0]   symTab    [SYM_N];

  always_ff @(posedge clk) begin
    if (cfgWe && cfgSel == CFG_XLAT)
      xlatMem[cfgAddr[LAT_AW-1:0]] <= cfgData[ADDR_W-1:2];
    if (cfgWe && cfgSel == CFG_SYM)
      symTab[cfgAddr[SYM_W-1:0]] <= cfgData[SYM_W-1:0];
  end

  generate
    for (genvar g = 0; g < MAX_LEN; g++) begin : gLenTab
      always_ff @(posedge clk) begin
        if (!rstN) begin
          firstCode[g] <= '0;
          codeCnt[g]   <= '0;
          codeBase[g]  <= '0;
        end else if (cfgWe && cfgAddr[LEN_IW-1:0] == LEN_IW'(g)) begin
          if (cfgSel == CFG_FIRST)
            firstCode[g] <= cfgData[MAX_LEN-1:0];
          if (cfgSel == CFG_CNTBASE) begin
            codeCnt[g]  <= cfgData[SYM_W:0];
            codeBase[g] <= cfgData[BASE_LSB +: SYM_W];
          end
        end
      end
    end
  endgenerate

  // ---------------- state ----------------
  logic [BUF_W-1:0]   bitBuf;
  logic [CNT_W-1:0]   bufCnt;
  logic [MAX_LEN-2:0] codeReg;
  logic [LEN_IW-1:0]  codeLen;   // bits already taken for current code
  logic [SIDX_W-1:0]  symIdx;
  logic               codeErrR;
  logic [PTR_W-1:0]   fetchPtr;
  logic [LINE_W-1:0]  lineBuf;

  assign lineFull = (symIdx == SIDX_W'(LINE_SYMS));
  assign codeErr  = codeErrR;
  assign lineData = lineBuf;

  // ---------------- canonical decode step ----------------
  logic [MAX_LEN-1:0] nextCode;
  logic [MAX_LEN:0]   codeDiff;
  logic               codeHit;
  logic [SYM_W-1:0]   symAddr;
  logic [SYM_W-1:0]   decSym;
  logic               step;

  assign step     = strobe.run && !lineFull && !codeErrR && (bufCnt != '0);
  assign nextCode = {codeReg, bitBuf[BUF_W-1]};
  assign codeDiff = {1'b0, nextCode} - {1'b0, firstCode[codeLen]};
  assign codeHit  = !codeDiff[MAX_LEN] &&
                    (codeDiff[MAX_LEN-1:0] < {{(MAX_LEN-SYM_W-1){1'b0}}, codeCnt[codeLen]});
  assign symAddr  = codeBase[codeLen] + codeDiff[SYM_W-1:0];
  assign decSym   = symTab[symAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg  <= '0;
      codeLen  <= '0;
      symIdx   <= '0;
      codeErrR <= 1'b0;
    end else if (strobe.start) begin
      codeReg  <= '0;
      codeLen  <= '0;
      symIdx   <= '0;
      codeErrR <= 1'b0;
    end else if (step) begin
      if (codeHit) begin
        codeReg <= '0;
        codeLen <= '0;
        symIdx  <= symIdx + 1'b1;
      end else if (codeLen == LEN_IW'(MAX_LEN - 1)) begin
        codeErrR <= 1'b1;
      end else begin
        codeReg <= nextCode[MAX_LEN-2:0];
        codeLen <= codeLen + 1'b1;
      end
    end
  end

  // line assembly, one register slice per symbol slot
  generate
    for (genvar s = 0; s < LINE_SYMS; s++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN)
          lineBuf[s*SYM_W +: SYM_W] <= '0;
        else if (step && codeHit && symIdx[SSEL_W-1:0] == SSEL_W'(s))
          lineBuf[s*SYM_W +: SYM_W] <= decSym;
      end
    end
  endgenerate

  // ---------------- bit buffer ----------------
  logic [BUF_W-1:0] shifted;
  logic [BUF_W-1:0] bufNext;
  logic [CNT_W-1:0] cntAfter;
  logic [CNT_W-1:0] cntNext;
  logic             take;

  assign take = refPend && memRespValid && strobe.run;

  always_comb begin
    shifted  = step ? (bitBuf << 1) : bitBuf;
    cntAfter = bufCnt - CNT_W'(step);
    bufNext  = shifted;
    cntNext  = cntAfter;
    if (take) begin
      bufNext = shifted | ({memRespData, {(BUF_W-MEM_W){1'b0}}} >> cntAfter);
      cntNext = cntAfter + CNT_W'(MEM_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.start) begin
      bitBuf <= '0;
      bufCnt <= '0;
    end else begin
      bitBuf <= bufNext;
      bufCnt <= cntNext;
    end
  end

  // ---------------- compressed word fetch ----------------
  assign fetchValid = strobe.run && !refPend && !lineFull && !codeErrR &&
                      (bufCnt < CNT_W'(MAX_LEN));
  assign fetchAddr  = {fetchPtr, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPtr <= '0;
      refPend  <= 1'b0;
    end else begin
      if (strobe.start)
        fetchPtr <= xlatMem[lineIdx];
      else if (fetchValid && memReqReady)
        fetchPtr <= fetchPtr + 1'b1;
      if (fetchValid && memReqReady)
        refPend <= 1'b1;
      else if (memRespValid)
        refPend <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  assert_buf_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    bufCnt <= CNT_W'(BUF_W));

  assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    symIdx <= SIDX_W'(LINE_SYMS));

  assert_fresh_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (bufCnt == '0 && symIdx == '0 && !codeErrR));

  assert_fetch_then_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && memReqReady) |=> refPend);

endmodule

// File: rtl/clr_ctrl.sv
module clr_ctrl
  import clr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        dReqValid,
  input  logic        dReqWe,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        lineFull,
  input  logic        codeErr,
  input  logic        refPend,
  output ctrlStrobe_t strobe,
  output logic        dGrant,
  output logic        dReqReady,
  output logic        dRespValid,
  output logic        lineValid,
  output logic        lineErr
);

  refillState_t state;
  refillState_t stateNext;
  logic         dOut;   // one data read waiting for its response

  always_comb begin
    strobe.start = (state == ST_IDLE) && missValid && !dOut;
    strobe.run   = (state == ST_FILL);
    stateNext    = state;
    case (state)
      ST_IDLE:  if (strobe.start) stateNext = ST_FILL;
      ST_FILL:  if (lineFull || codeErr) stateNext = ST_DRAIN;
      ST_DRAIN: if (!refPend) stateNext = codeErr ? ST_ERR : ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      ST_ERR:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign dGrant     = (state == ST_IDLE) && !missValid && !dOut;
  assign dReqReady  = dGrant && memReqReady;
  assign dRespValid = memRespValid && dOut;
  assign lineValid  = (state == ST_DONE);
  assign lineErr    = (state == ST_ERR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dOut  <= 1'b0;
    end else begin
      state <= stateNext;
      if (dReqValid && dReqReady && !dReqWe)
        dOut <= 1'b1;
      else if (memRespValid)
        dOut <= 1'b0;
    end
  end

  assert_done_means_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> lineFull);

  assert_err_means_bad_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERR) |-> codeErr);

  assert_line_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |=> !lineValid);

  assert_no_data_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !dReqReady);

  assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRespValid |-> !(dOut && refPend));

endmodule

// File: rtl/cline_refill.sv
module cline_refill
  import clr_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int LINE_SYMS = 32,
  parameter int MAX_LEN   = 16,
  parameter int LAT_AW    = 8,
  parameter int MEM_W     = 32,
  parameter int BUF_W     = 64,
  parameter int ADDR_W    = 32,
  localparam int CFG_AW   = (LAT_AW > SYM_W) ? LAT_AW : SYM_W,
  localparam int LINE_W   = SYM_W * LINE_SYMS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [MEM_W-1:0]  cfgData,
  input  logic              missValid,
  input  logic [LAT_AW-1:0] missLine,
  output logic              lineValid,
  output logic              lineErr,
  output logic [LINE_W-1:0] lineData,
  input  logic              dReqValid,
  output logic              dReqReady,
  input  logic              dReqWe,
  input  logic [ADDR_W-1:0] dReqAddr,
  input  logic [MEM_W-1:0]  dReqWdata,
  output logic              dRespValid,
  output logic [MEM_W-1:0]  dRespData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWe,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [MEM_W-1:0]  memReqWdata,
  input  logic              memRespValid,
  input  logic [MEM_W-1:0]  memRespData
);

  ctrlStrobe_t       strobe;
  logic              dGrant;
  logic              fetchValid;
  logic [ADDR_W-1:0] fetchAddr;
  logic              lineFull;
  logic              codeErr;
  logic              refPend;

  clr_ctrl u_ctrl (
    .clk, .rstN, .missValid, .dReqValid, .dReqWe, .memReqReady, .memRespValid,
    .lineFull, .codeErr, .refPend, .strobe, .dGrant, .dReqReady, .dRespValid,
    .lineValid, .lineErr
  );

  clr_dpath #(
    .SYM_W(SYM_W), .LINE_SYMS(LINE_SYMS), .MAX_LEN(MAX_LEN), .LAT_AW(LAT_AW),
    .MEM_W(MEM_W), .BUF_W(BUF_W), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)
  ) u_dpath (
    .clk, .rstN, .strobe, .cfgWe, .cfgSel, .cfgAddr, .cfgData,
    .lineIdx(missLine), .memReqReady, .memRespValid, .memRespData,
    .fetchValid, .fetchAddr, .lineFull, .codeErr, .refPend, .lineData
  );

  // shared memory port: data side only while granted
  assign memReqValid = dGrant ? dReqValid : fetchValid;
  assign memReqAddr  = dGrant ? dReqAddr  : fetchAddr;
  assign memReqWe    = dGrant && dReqWe;
  assign memReqWdata = dReqWdata;
  assign dRespData   = memRespData;

  assert_miss_blocks_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> !dReqReady);

  assert_data_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dReqValid && dReqReady) |-> (memReqValid && memReqAddr == dReqAddr &&
                                  memReqWe == dReqWe));

endmodule

// File: tb/cline_refill_bench.sv
module cline_refill_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWe = 1'b0;
  logic [1:0]   cfgSel = '0;
  logic [7:0]   cfgAddr = '0;
  logic [31:0]  cfgData = '0;
  logic         missValid = 1'b0;
  logic [7:0]   missLine = '0;
  logic         lineValid, lineErr;
  logic [255:0] lineData;
  logic         dReqValid = 1'b0;
  logic         dReqReady;
  logic         dReqWe = 1'b0;
  logic [31:0]  dReqAddr = '0;
  logic [31:0]  dReqWdata = '0;
  logic         dRespValid;
  logic [31:0]  dRespData;
  logic         memReqValid, memReqWe;
  logic         memReqReady;
  logic [31:0]  memReqAddr, memReqWdata;
  logic         memRespValid;
  logic [31:0]  memRespData;

  always #2 clk = ~clk;   // 250 MHz

  cline_refill u_cline_refill (.*);

  // ---------------- memory model ----------------
  logic [31:0] mem [4096];
  int          cyc = 0;
  int          reqNum = 0;
  logic        pend = 1'b0;
  int          pendCnt = 0;
  logic [31:0] pendData = '0;
  logic        respV = 1'b0;
  logic [31:0] respD = '0;
  int          pendViol = 0, bypViol = 0;
  int          wrCount = 0;
  logic [31:0] lastWrAddr = '0, lastWrData = '0;
  logic [31:0] fetchLog [1024];
  int          fetchN = 0;

  assign memReqReady  = (cyc % 5) != 3;
  assign memRespValid = respV;
  assign memRespData  = respD;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    respV <= 1'b0;
    if (!rstN) begin
      pend <= 1'b0;
    end else begin
      if (pend) begin
        if (pendCnt == 0) begin respV <= 1'b1; respD <= pendData; pend <= 1'b0; end
        else pendCnt <= pendCnt - 1;
      end
      if (memReqValid && memReqReady) begin
        if (memReqWe) begin
          wrCount <= wrCount + 1; lastWrAddr <= memReqAddr; lastWrData <= memReqWdata;
        end else begin
          if (pend) pendViol <= pendViol + 1;
          pend <= 1'b1; pendCnt <= reqNum % 3; pendData <= mem[memReqAddr[13:2]];
          reqNum <= reqNum + 1;
          if (missValid) begin
            fetchLog[fetchN % 1024] <= memReqAddr; fetchN <= fetchN + 1;
          end
        end
      end
      if (missValid && dReqReady) bypViol <= bypViol + 1;
    end
  end

  // ---------------- counters and watchdog ----------------
  int checks = 0, errs = 0;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- canonical code built in the bench ----------------
  int cntL [17];
  int firstL [17];
  int baseL [17];

  function automatic int symOf(int j); return (37 * j + 11) % 256; endfunction
  function automatic int lenOf(int j); return (j < 2) ? 2 : (j < 4) ? 4 : 10; endfunction
  function automatic int codeOf(int j);
    int l = lenOf(j);
    return firstL[l] + (j - baseL[l]);
  endfunction
  function automatic int idxOf(int pat, int n, int i);
    case (pat)
      0: return 0;
      1: return i % 4;
      2: return 4 + ((i * 7 + n) % 252);
      default: return (n * 32 + i) % 256;
    endcase
  endfunction

  task automatic cfgWrite(input int sel, input int a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgAddr = 8'(a); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  int bp = 0;
  task automatic putBits(input int code, input int len);
    for (int k = len - 1; k >= 0; k--) begin
      mem[bp / 32][31 - (bp % 32)] = 1'((code >> k) & 1);
      bp++;
    end
  endtask

  // test lines
  logic [255:0] expLine [12];
  int           lineK   [12];
  int           lineStart [12];

  task automatic doRefill(input int k, input logic [255:0] exp, input bit expErr,
                          input int startByte, input bit alreadyAligned);
    int base0, waitC;
    bit gotV, gotE;
    logic [255:0] act;
    if (!alreadyAligned) @(negedge clk);
    base0 = fetchN;
    missValid = 1'b1; missLine = 8'(k);
    waitC = 0;
    do begin @(negedge clk); waitC++; end
    while (!lineValid && !lineErr && waitC < 5000);
    gotV = lineValid; gotE = lineErr; act = lineData;
    missValid = 1'b0;
    if (expErr) begin
      chk(gotE && !gotV, "R6 error pulse", {254'b0, gotE, gotV}, 256'b10);
    end else begin
      chk(gotV && !gotE, "R4 line valid", {254'b0, gotE, gotV}, 256'b01);
      chk(act == exp, "R3 R5 line data", act, exp);
    end
    chk(fetchN > base0 && fetchLog[base0 % 1024] == startByte, "R2 first fetch",
        256'(fetchLog[base0 % 1024]), 256'(startByte));
    for (int q = base0 + 1; q < fetchN; q++)
      chk(fetchLog[q % 1024] == fetchLog[(q - 1) % 1024] + 4, "R2 sequential fetch",
          256'(fetchLog[q % 1024]), 256'(fetchLog[(q - 1) % 1024] + 4));
    @(negedge clk);
    chk(!lineValid && !lineErr, "R4 single-cycle pulse", {254'b0, lineErr, lineValid}, 256'b0);
  endtask

  task automatic dataFinish(input logic [31:0] exp);
    int waitC = 0;
    while (!dReqReady && waitC < 5000) begin @(negedge clk); waitC++; end
    @(negedge clk);
    dReqValid = 1'b0;
    while (!dRespValid && waitC < 5000) begin @(negedge clk); waitC++; end
    chk(dRespValid && dRespData == exp, "R7 data read", 256'(dRespData), 256'(exp));
  endtask

  initial begin
    for (int w = 0; w < 4096; w++) mem[w] = 32'hFFFF_FFFF;

    // reset state R1
    repeat (3) @(negedge clk);
    chk(!lineValid && !lineErr && !memReqValid && !dRespValid, "R1 reset outputs",
        {252'b0, lineValid, lineErr, memReqValid, dRespValid}, 256'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!lineValid && !lineErr && !memReqValid && !dRespValid, "R1 after reset",
        {252'b0, lineValid, lineErr, memReqValid, dRespValid}, 256'b0);

    // canonical code: 2 codes of length 2, 2 of length 4, 252 of length 10
    for (int l = 0; l <= 16; l++) cntL[l] = 0;
    cntL[2] = 2; cntL[4] = 2; cntL[10] = 252;
    firstL[0] = 0; baseL[0] = 0;
    for (int l = 1; l <= 16; l++) begin
      firstL[l] = (firstL[l - 1] + cntL[l - 1]) * 2;
      baseL[l]  = baseL[l - 1] + cntL[l - 1];
    end
    for (int l = 1; l <= 16; l++) begin
      cfgWrite(1, l - 1, 32'(firstL[l]));
      cfgWrite(2, l - 1, (32'(baseL[l] % 256) << 16) | 32'(cntL[l]));
    end
    for (int j = 0; j < 256; j++) cfgWrite(3, j, 32'(symOf(j)));

    // build image: padding and spare words stay all ones
    bp = 16 * 32;
    for (int t = 0; t < 12; t++) begin
      int pat, n;
      pat = (t < 4) ? ((t < 2) ? t : 2) : 3;
      n   = (t == 3) ? 5 : (t >= 4 ? t - 4 : 0);
      lineStart[t] = (bp / 32) * 4;
      lineK[t] = (t * 53 + 7) % 256;
      for (int i = 0; i < 32; i++) begin
        int j = idxOf(pat, n, i);
        putBits(codeOf(j), lenOf(j));
        expLine[t][8 * i +: 8] = 8'(symOf(j));
      end
      bp = ((bp + 31) / 32) * 32 + 32;
      cfgWrite(0, lineK[t], 32'(lineStart[t]));
    end
    cfgWrite(0, 200, 32'(3000 * 4));

    // refills out of order: R2 R3 R4 R5
    for (int s = 0; s < 12; s++) begin
      int t = (s * 5) % 12;
      doRefill(lineK[t], expLine[t], 1'b0, lineStart[t], 1'b0);
    end

    // invalid code R6, then recovery R5
    doRefill(200, '0, 1'b1, 3000 * 4, 1'b0);
    doRefill(lineK[0], expLine[0], 1'b0, lineStart[0], 1'b0);
    doRefill(lineK[2], expLine[2], 1'b0, lineStart[2], 1'b0);
    doRefill(lineK[2], expLine[2], 1'b0, lineStart[2], 1'b0);

    // data bypass R7
    @(negedge clk);
    dReqValid = 1'b1; dReqWe = 1'b0; dReqAddr = 32'(16 * 4);
    dataFinish(mem[16]);
    @(negedge clk);
    dReqValid = 1'b1; dReqWe = 1'b0; dReqAddr = 32'(3000 * 4 + 8);
    dataFinish(mem[3002]);
    begin
      int w0 = wrCount;
      @(negedge clk);
      dReqValid = 1'b1; dReqWe = 1'b1; dReqAddr = 32'h0000_1234; dReqWdata = 32'hA5C3_0F96;
      while (!dReqReady) @(negedge clk);
      @(negedge clk);
      dReqValid = 1'b0; dReqWe = 1'b0;
      @(negedge clk);
      chk(wrCount == w0 + 1 && lastWrAddr == 32'h0000_1234 && lastWrData == 32'hA5C3_0F96,
          "R7 data write passthrough", {lastWrAddr, lastWrData}, {32'h0000_1234, 32'hA5C3_0F96});
    end

    // data read raised together with a miss: R9
    @(negedge clk);
    dReqValid = 1'b1; dReqWe = 1'b0; dReqAddr = 32'(lineStart[5]);
    doRefill(lineK[5], expLine[5], 1'b0, lineStart[5], 1'b1);
    dataFinish(mem[lineStart[5] / 4]);

    repeat (5) @(negedge clk);
    chk(pendViol == 0, "R8 one refill read outstanding", 256'(pendViol), 256'd0);
    chk(bypViol == 0, "R9 data blocked during miss", 256'(bypViol), 256'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule